// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block receives asynchronous serial characters on a single input line. It uses a sixteen-times oversampling tick that is generated elsewhere. While reception is enabled, a falling edge on the idle-high line begins a start bit. The block confirms the start bit at its midpoint, then samples 8 or 9 bits, least significant first, each in the middle of its bit time. It then checks the stop bit. A completed character moves from the shift stage into a receive buffer that software can read. A new character can therefore arrive while the previous one is still waiting to be read.

The block checks three error conditions. The first is an optional even parity check on the ninth bit. The second is framing, where the stop bit is sampled low. The third is overrun, where a second character completes before the buffer has been read. Each error sets a sticky flag that holds until a clear strobe. There is one interrupt pulse for every received character and a separate pulse for a character received with errors.

Top module: `async_rx_unit`

## Requirements
- R1: Characters are received only while `rx_en` is 1. A character whose reception is cut short by `rx_en` going to 0 produces no interrupt and leaves the buffer unchanged.
- R2: A low level on `rxd` starts a start bit, which is sampled again after 8 oversampling ticks. If `rxd` is high at that point, the event is treated as a glitch and no character is produced.
- R3: Data bits are received least significant bit first, each held for 16 ticks. There are 8 bits when `nine_bit` is 0 and 9 bits when `nine_bit` is 1.
- R4: Receive buffer layout:
  - `rbuf[7:0]` holds the first eight received bits.
  - `rbuf[8]` holds the ninth received bit (data or parity) when `nine_bit` is 1, and is 0 otherwise.
  - `rbuf[15:9]` always reads 0.
- R5: When `nine_bit` and `par_en` are both 1, the ninth bit is even parity over bits 7:0. A mismatch sets `pe_flag` and pulses `err_irq`. `par_en` has no effect when `nine_bit` is 0.
- R6: A stop bit sampled low sets `fe_flag` and pulses `err_irq`. The character is still stored.
- R7: If `ovr_en` is 1 and a character completes while `rbuf_full` is 1, with no read in that cycle, then `oe_flag` is set, `err_irq` pulses, and the new character replaces the old one. If `ovr_en` is 0, the new character replaces the old one with no flag and no error pulse.
- R8: `rx_irq` pulses for one cycle for each completed character. `err_irq` pulses in the same cycle only if that character had a parity, framing or overrun error.
- R9: `pe_flag`, `fe_flag` and `oe_flag` stay set until an `err_clr` pulse. A new error arriving in the same cycle as `err_clr` wins.
- R10: Completing a character sets `rbuf_full`. A `rd_strobe` pulse clears `rbuf_full` and leaves `rbuf` unchanged.
- R11: Reception of the next character proceeds while the buffer still holds an unread character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1: nine bits per character, 0: eight |
| par_en | input | 1 | Ninth bit is even parity (nine-bit mode only) |
| ovr_en | input | 1 | Overrun detection enable |
| rxd | input | 1 | Serial data line, idle high |
| rd_strobe | input | 1 | Buffer read pulse |
| err_clr | input | 1 | Clears the sticky error flags |
| rbuf | output | 16 | Receive buffer |
| rbuf_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | Character-received pulse |
| err_irq | output | 1 | Erroneous-reception pulse |
| pe_flag | output | 1 | Sticky parity error |
| fe_flag | output | 1 | Sticky framing error |
| oe_flag | output | 1 | Sticky overrun error |

## Verification
The `rxd` line passes through two synchronizer flops. The receiver samples the stop bit on the eighth tick after that bit starts. The character is loaded into `rbuf` two clocks later, in the same cycle that `rx_irq` and `err_irq` pulse. This is well inside the stop bit plus the idle bit that the bench drives afterwards.

A scoreboard monitor samples on falling clock edges whenever `rx_irq` is high. At that moment it compares `rbuf`, `err_irq`, `rbuf_full` and the three flags against the oldest queued expectation.

Reads and flag clears are issued only between characters. Their effect is checked one clock later. For stimuli that must produce nothing (disabled receiver, glitches, aborted characters), the bench waits past the time a character would have finished and then confirms that the interrupt count and buffer state did not change.

// File: rtl/async_rx_pkg.sv
// Shared definitions for the asynchronous receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package async_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
// Synchronizer chain that brings the asynchronous serial line into the clock domain.
// Assumes: STAGES >= 2; resets to 1, the idle level of the line.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
// Bit-level receive state machine. It finds the start bit, samples each bit at
// the middle of its bit time and hands over the assembled word with the stop sample.
// Assumes: nine_bit is stable during a character; tick is a one-cycle pulse.
module rx_framer
    import async_rx_pkg::*;
#(
    parameter int BASE_BITS = 8,
    parameter int OS_RATE   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               enable,
    input  logic               nine_bit,
    input  logic               rxd_s,
    output logic               done,
    output logic [BASE_BITS:0] word,
    output logic               stop_ok
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam int IDX_W = $clog2(BASE_BITS + 2);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OS_RATE - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   last_idx;
    logic [BASE_BITS:0] shreg;

    assign last_idx = nine_bit ? IDX_W'(BASE_BITS) : IDX_W'(BASE_BITS - 1);

    // Step through start, data and stop bits on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
                cnt   <= '0;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID_LAST) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= rxd_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == BIT_LAST) begin
                            cnt   <= '0;
                            shreg <= {rxd_s, shreg[BASE_BITS:1]};
                            idx   <= idx + 1'b1;
                            if (idx == last_idx) state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == BIT_LAST) begin
                            cnt     <= '0;
                            state   <= RX_IDLE;
                            done    <= 1'b1;
                            stop_ok <= rxd_s;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // Right-align the word: an eight-bit character sits one place higher in the shifter.
    assign word = nine_bit ? shreg : {1'b0, shreg[BASE_BITS:1]};

    AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == RX_IDLE); // R1
    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state == RX_START && cnt == MID_LAST && rxd_s) |=> state == RX_IDLE); // R2
    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == RX_STOP); // R8
endmodule

// File: rtl/rx_buffer.sv
// Receive buffer stage with error evaluation, sticky flags and interrupt pulses.
// Assumes: done is a one-cycle pulse and frames are far apart compared with a clock.
module rx_buffer #(
    parameter int BASE_BITS = 8,
    parameter int BUF_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done,
    input  logic [BASE_BITS:0] word,
    input  logic               stop_ok,
    input  logic               nine_bit,
    input  logic               par_en,
    input  logic               ovr_en,
    input  logic               rd,
    input  logic               err_clr,
    output logic [BUF_W-1:0]   rbuf,
    output logic               full,
    output logic               rx_irq,
    output logic               err_irq,
    output logic [2:0]         flags
);
    localparam int PAD = BUF_W - BASE_BITS - 1;

    logic       par_bad, frm_bad, ovr_hit;
    logic [2:0] new_err;

    assign par_bad = nine_bit && par_en && (^word);
    assign frm_bad = !stop_ok;
    assign ovr_hit = ovr_en && full && !rd;
    assign new_err = {ovr_hit, frm_bad, par_bad} & {3{done}};

    // Load the buffer on completion; a read empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf <= '0;
            full <= 1'b0;
        end else if (done) begin
            rbuf <= {{PAD{1'b0}}, word};
            full <= 1'b1;
        end else if (rd) begin
            full <= 1'b0;
        end
    end

    // Raise one-cycle interrupt pulses for each completed character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_irq  <= 1'b0;
            err_irq <= 1'b0;
        end else begin
            rx_irq  <= done;
            err_irq <= |new_err;
        end
    end

    // Sticky flags: bit 0 parity, bit 1 framing, bit 2 overrun; set wins over clear.
    for (genvar i = 0; i < 3; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= new_err[i] | (flags[i] & !err_clr);
        end
    end

    AST_OVR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovr_en && full && !rd) |=> (flags[2] && err_irq)); // R7
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> (!full && $stable(rbuf))); // R10
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((flags & $past(flags)) == $past(flags))); // R9
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R8
    AST_ERR_WITH_RX: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> rx_irq); // R8
endmodule

// File: rtl/async_rx_unit.sv
// Asynchronous serial receiver top: synchronizer, bit framer and buffer stage.
// Assumes: os_tick pulses at OS_RATE times the bit rate; mode inputs change only between characters.
module async_rx_unit #(
    parameter int BASE_BITS   = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rx_en,
    input  logic             nine_bit,
    input  logic             par_en,
    input  logic             ovr_en,
    input  logic             rxd,
    input  logic             rd_strobe,
    input  logic             err_clr,
    output logic [BUF_W-1:0] rbuf,
    output logic             rbuf_full,
    output logic             rx_irq,
    output logic             err_irq,
    output logic             pe_flag,
    output logic             fe_flag,
    output logic             oe_flag
);
    logic               rxd_s;
    logic               frm_done;
    logic               frm_stop_ok;
    logic [BASE_BITS:0] frm_word;
    logic [2:0]         flag_vec;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    rx_framer #(.BASE_BITS(BASE_BITS), .OS_RATE(OS_RATE)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .enable(rx_en),
        .nine_bit(nine_bit), .rxd_s(rxd_s), .done(frm_done),
        .word(frm_word), .stop_ok(frm_stop_ok)
    );

    rx_buffer #(.BASE_BITS(BASE_BITS), .BUF_W(BUF_W)) u_buffer (
        .clk(clk), .rst_n(rst_n), .done(frm_done), .word(frm_word),
        .stop_ok(frm_stop_ok), .nine_bit(nine_bit), .par_en(par_en),
        .ovr_en(ovr_en), .rd(rd_strobe), .err_clr(err_clr), .rbuf(rbuf),
        .full(rbuf_full), .rx_irq(rx_irq), .err_irq(err_irq), .flags(flag_vec)
    );

    assign pe_flag = flag_vec[0];
    assign fe_flag = flag_vec[1];
    assign oe_flag = flag_vec[2];
endmodule

// File: tb/async_rx_unit_tb.sv
// Scoreboard bench: the driver queues expected characters, the monitor checks them on rx_irq.
module async_rx_unit_tb;
    localparam int BIT_CLKS = 64; // 16 ticks of 4 clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic rx_en = 1'b0, nine_bit = 1'b0, par_en = 1'b0, ovr_en = 1'b0;
    logic rxd = 1'b1, rd_strobe = 1'b0, err_clr = 1'b0;
    logic [15:0] rbuf;
    logic rbuf_full, rx_irq, err_irq, pe_flag, fe_flag, oe_flag;

    typedef struct packed {
        logic [15:0] word;
        logic        err;
        logic        pe, fe, oe;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0, checks = 0, irq_count = 0;
    logic m_pe = 0, m_fe = 0, m_oe = 0, m_full = 0;
    logic [15:0] m_last = '0;
    logic [1:0] tcnt = '0;

    always #2 clk = ~clk;

    async_rx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en),
        .nine_bit(nine_bit), .par_en(par_en), .ovr_en(ovr_en), .rxd(rxd),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .rbuf(rbuf),
        .rbuf_full(rbuf_full), .rx_irq(rx_irq), .err_irq(err_irq),
        .pe_flag(pe_flag), .fe_flag(fe_flag), .oe_flag(oe_flag)
    );

    // Oversampling tick: one clock in four.
    always @(negedge clk) begin
        tcnt    <= tcnt + 2'd1;
        os_tick <= (tcnt == 2'd2);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each completed character against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin
            exp_t e;
            irq_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected character", int'(rbuf), 0);
            end else begin
                e = exp_q.pop_front();
                check(rbuf == e.word, "R3/R4 buffer contents", int'(rbuf), int'(e.word));
                check(err_irq == e.err, "R8 error pulse", int'(err_irq), int'(e.err));
                check(pe_flag == e.pe, "R5 parity flag", int'(pe_flag), int'(e.pe));
                check(fe_flag == e.fe, "R6 framing flag", int'(fe_flag), int'(e.fe));
                check(oe_flag == e.oe, "R7/R11 overrun flag", int'(oe_flag), int'(e.oe));
                check(rbuf_full == 1'b1, "R10 full after load", int'(rbuf_full), 1);
            end
        end
    end

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Driver: send one character and queue its expected result when reception is on.
    task automatic send(input logic [8:0] d, input logic stop_hi);
        exp_t e;
        logic pe, fe, oe;
        int   nb = nine_bit ? 9 : 8;
        if (rx_en) begin
            pe = nine_bit && par_en && (^d);
            fe = !stop_hi;
            oe = ovr_en && m_full;
            m_pe = m_pe | pe; m_fe = m_fe | fe; m_oe = m_oe | oe;
            e.word = nine_bit ? {7'd0, d} : {8'd0, d[7:0]};
            e.err = pe | fe | oe;
            e.pe = m_pe; e.fe = m_fe; e.oe = m_oe;
            exp_q.push_back(e);
            m_full = 1'b1;
            m_last = e.word;
        end
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        drive_bit(stop_hi);
        drive_bit(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        m_full = 1'b0;
        check(rbuf_full == 1'b0, "R10 read clears full", int'(rbuf_full), 0);
        check(rbuf == m_last, "R10 read keeps data", int'(rbuf), int'(m_last));
    endtask

    task automatic do_clear();
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        m_pe = 0; m_fe = 0; m_oe = 0;
        check({pe_flag, fe_flag, oe_flag} == 3'b000, "R9 clear flags",
              int'({pe_flag, fe_flag, oe_flag}), 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rbuf == 16'h0 && !rbuf_full && !rx_irq && !err_irq, "R10 reset state",
              int'({rbuf_full, rbuf}), 0);
        check({pe_flag, fe_flag, oe_flag} == 3'b000, "R9 reset flags",
              int'({pe_flag, fe_flag, oe_flag}), 0);
        rx_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R3 R4: plain eight-bit character
        send(9'h0A5, 1'b1); do_read();
        // R5: parity enable ignored in eight-bit mode (odd count of ones)
        par_en = 1'b1; send(9'h007, 1'b1); do_read(); par_en = 1'b0;
        // R4: nine data bits
        nine_bit = 1'b1; send(9'h15A, 1'b1); do_read();
        // R5: good and bad even parity
        par_en = 1'b1;
        send(9'h081, 1'b1); do_read();
        send(9'h013, 1'b1); do_read();
        do_clear();
        par_en = 1'b0; nine_bit = 1'b0;
        // R6: missing stop bit, then R9 flag stays set over a clean character
        send(9'h05C, 1'b0); do_read();
        send(9'h0C3, 1'b1); do_read();
        do_clear();
        // R7 R11: second character completes before the first is read
        ovr_en = 1'b1;
        send(9'h011, 1'b1); send(9'h022, 1'b1); do_read();
        do_clear();
        // R7: overrun detection off, silent overwrite
        ovr_en = 1'b0;
        send(9'h033, 1'b1); send(9'h044, 1'b1); do_read();

        // R1: receiver disabled for a whole character
        base = irq_count;
        rx_en = 1'b0; send(9'h0FF, 1'b1);
        check(irq_count == base && !rbuf_full, "R1 disabled receiver", irq_count - base, 0);
        rx_en = 1'b1;
        // R2: short low glitch is rejected
        rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check(irq_count == base && !rbuf_full && rbuf == m_last, "R2 glitch rejected",
              irq_count - base, 0);
        // R1: abort in mid-character
        drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0);
        rx_en = 1'b0;
        for (int i = 0; i < 6; i++) drive_bit(1'b1);
        rx_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        check(irq_count == base && rbuf == m_last && !rbuf_full, "R1 aborted character",
              int'(rbuf), int'(m_last));
        // R1: receiver recovers after the abort
        send(9'h096, 1'b1); do_read();

        repeat (BIT_CLKS) @(negedge clk);
        check(exp_q.size() == 0, "R8 all characters signalled", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule